// File: doc/BRIEF.md
# 4:2:0 Frame Buffer Scan Addresser

This block walks the active area of a raster display one pixel per accepted beat and produces, for every pixel, the two read addresses a 4:2:0 frame buffer needs. The luminance plane holds one byte per pixel. The two colour-difference planes each hold one byte per 2x2 pixel group, so a group costs 48 bits: four luma bytes, one U byte and one V byte. The luma address is the linear pixel index. The chroma address indexes the half-resolution plane, and the same chroma address is used by both colour-difference arrays. At the default size of 1600x1200 refreshed 30 times a second, the pixel rate is about 57.6 MHz.

Each beat also carries the pixel's row and column, its position inside its 2x2 group, and markers for the first pixel of a line and of a frame. The output is a valid/ready stream. The downstream fetch or colour-conversion stage applies back-pressure by holding `pix_ready` low. While it does, the scan freezes and the presented beat stays unchanged. No blanking intervals are generated, so the beats of one frame follow each other with no gap.

Top module: `yuv420_scan_addr`

## Requirements
- R1: While `rst` is high at a clock edge, `pix_valid` is low after that edge. The first beat after reset is released is row 0, column 0, luma address 0, chroma address 0, with `frame_start` and `line_start` both high.
- R2: Accepted beats follow raster order. The column rises from 0 to COLS-1, then wraps to 0 and the row advances by one.
- R3: `luma_addr` equals row*COLS + column.
- R4: `chroma_addr` equals (row/2)*(COLS/2) + column/2, using integer division.
- R5: `pix_quad` equals {row bit 0, column bit 0}. The codes are 0 for top-left, 1 for top-right, 2 for bottom-left and 3 for bottom-right within the 2x2 group.
- R6: `line_start` is high exactly on beats whose column is 0.
- R7: `frame_start` is high exactly on the beat at row 0, column 0.
- R8: A beat with `pix_valid` high and `pix_ready` low is held. In the next cycle `pix_valid` is still high and every data output keeps its value.
- R9: Once `pix_valid` has risen after reset, it stays high until the next reset. No beat is skipped and no bubble is inserted.
- R10: The beat after row ROWS-1, column COLS-1 is row 0, column 0, with luma address 0 and chroma address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_ready | input | 1 | Downstream accepts the presented beat |
| pix_valid | output | 1 | A beat is presented |
| luma_addr | output | clog2(COLS*ROWS) | Luma plane address |
| chroma_addr | output | clog2(COLS*ROWS/4) | Shared U/V plane address |
| pix_row | output | clog2(ROWS) | Row of the presented pixel |
| pix_col | output | clog2(COLS) | Column of the presented pixel |
| pix_quad | output | 2 | Position within the 2x2 group |
| line_start | output | 1 | First pixel of a line |
| frame_start | output | 1 | First pixel of a frame |

## Verification
The bench targets the places where an incremental chroma pointer goes wrong. At the end of an even row the pointer must rewind to the same chroma line, so a design that always advances would skip every second chroma line. At the end of an odd row the pointer must move on, so one that never advances would repeat the first chroma line down the whole frame. The frame wrap must clear both pointers, or the next frame would start at a stale offset. Back-pressure is applied with steady, pseudo-random and periodic ready patterns, which exposes a scan that advances while stalled or lets a held beat change. A reset in mid-frame must restart the scan at the origin.

// File: rtl/yuv420_scan_pkg.sv
package yuv420_scan_pkg;

  // Position of a pixel inside its 2x2 chroma group: {row lsb, col lsb}
  typedef enum logic [1:0] {
    QUAD_TL = 2'd0,
    QUAD_TR = 2'd1,
    QUAD_BL = 2'd2,
    QUAD_BR = 2'd3
  } quad_e;

  function automatic quad_e quad_of(input logic row_lsb, input logic col_lsb);
    return quad_e'({row_lsb, col_lsb});
  endfunction

endpackage

// File: rtl/ysc_wrap_counter.sv
module ysc_wrap_counter #(
  parameter int LIMIT = 1600,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         last
);

  assign last = (value == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (step) begin
      value <= last ? '0 : value + W'(1);
    end
  end

endmodule

// File: rtl/ysc_luma_ptr.sv
module ysc_luma_ptr #(
  parameter int PIXELS = 1600 * 1200,
  localparam int W = $clog2(PIXELS)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         frame_last,
  output logic [W-1:0] ptr
);

  // Linear pixel index: row*COLS+col grows by one per pixel in raster order
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (step) begin
      ptr <= frame_last ? '0 : ptr + W'(1);
    end
  end

endmodule

// File: rtl/ysc_chroma_ptr.sv
module ysc_chroma_ptr #(
  parameter int COLS = 1600,
  parameter int ROWS = 1200,
  localparam int HALF_COLS = COLS / 2,
  localparam int W = $clog2(HALF_COLS * (ROWS / 2))
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         col_odd,
  input  logic         col_last,
  input  logic         row_odd,
  input  logic         frame_last,
  output logic [W-1:0] ptr
);

  logic [W-1:0] line_base;

  // The pointer moves every second column. At a line end it rewinds to the
  // base after an even row and steps to the next chroma line after an odd row.
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      line_base <= '0;
    end else if (step) begin
      if (frame_last) begin
        ptr       <= '0;
        line_base <= '0;
      end else if (col_last) begin
        if (row_odd) begin
          ptr       <= line_base + W'(HALF_COLS);
          line_base <= line_base + W'(HALF_COLS);
        end else begin
          ptr <= line_base;
        end
      end else if (col_odd) begin
        ptr <= ptr + W'(1);
      end
    end
  end

endmodule

// File: rtl/yuv420_scan_addr.sv
module yuv420_scan_addr
  import yuv420_scan_pkg::*;
#(
  parameter int COLS = 1600,
  parameter int ROWS = 1200,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS),
  localparam int LUMA_W = $clog2(COLS * ROWS),
  localparam int CHROMA_W = $clog2((COLS / 2) * (ROWS / 2))
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pix_ready,
  output logic                pix_valid,
  output logic [LUMA_W-1:0]   luma_addr,
  output logic [CHROMA_W-1:0] chroma_addr,
  output logic [ROW_W-1:0]    pix_row,
  output logic [COL_W-1:0]    pix_col,
  output logic [1:0]          pix_quad,
  output logic                line_start,
  output logic                frame_start
);

  logic                load;
  logic [COL_W-1:0]    col_cnt;
  logic [ROW_W-1:0]    row_cnt;
  logic                col_last;
  logic                row_last;
  logic                frame_last;
  logic [LUMA_W-1:0]   luma_next;
  logic [CHROMA_W-1:0] chroma_next;
  quad_e               quad_next;

  // The output register takes a new beat when it is empty or being accepted
  assign load       = ~pix_valid | pix_ready;
  assign frame_last = col_last & row_last;
  assign quad_next  = quad_of(row_cnt[0], col_cnt[0]);

  ysc_wrap_counter #(.LIMIT(COLS)) u_col (
    .clk   (clk),
    .rst   (rst),
    .step  (load),
    .value (col_cnt),
    .last  (col_last)
  );

  ysc_wrap_counter #(.LIMIT(ROWS)) u_row (
    .clk   (clk),
    .rst   (rst),
    .step  (load & col_last),
    .value (row_cnt),
    .last  (row_last)
  );

  ysc_luma_ptr #(.PIXELS(COLS * ROWS)) u_luma (
    .clk        (clk),
    .rst        (rst),
    .step       (load),
    .frame_last (frame_last),
    .ptr        (luma_next)
  );

  ysc_chroma_ptr #(.COLS(COLS), .ROWS(ROWS)) u_chroma (
    .clk        (clk),
    .rst        (rst),
    .step       (load),
    .col_odd    (col_cnt[0]),
    .col_last   (col_last),
    .row_odd    (row_cnt[0]),
    .frame_last (frame_last),
    .ptr        (chroma_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid   <= 1'b0;
      luma_addr   <= '0;
      chroma_addr <= '0;
      pix_row     <= '0;
      pix_col     <= '0;
      pix_quad    <= QUAD_TL;
      line_start  <= 1'b0;
      frame_start <= 1'b0;
    end else if (load) begin
      pix_valid   <= 1'b1;
      luma_addr   <= luma_next;
      chroma_addr <= chroma_next;
      pix_row     <= row_cnt;
      pix_col     <= col_cnt;
      pix_quad    <= quad_next;
      line_start  <= (col_cnt == '0);
      frame_start <= (col_cnt == '0) && (row_cnt == '0);
    end
  end

endmodule

// File: rtl/yuv420_scan_chk.sv
module yuv420_scan_chk #(
  parameter int COLS = 1600,
  parameter int ROWS = 1200,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS),
  localparam int LUMA_W = $clog2(COLS * ROWS),
  localparam int CHROMA_W = $clog2((COLS / 2) * (ROWS / 2))
) (
  input logic                clk,
  input logic                rst,
  input logic                pix_ready,
  input logic                pix_valid,
  input logic [LUMA_W-1:0]   luma_addr,
  input logic [CHROMA_W-1:0] chroma_addr,
  input logic [ROW_W-1:0]    pix_row,
  input logic [COL_W-1:0]    pix_col,
  input logic [1:0]          pix_quad,
  input logic                line_start,
  input logic                frame_start
);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid && !pix_ready |=> pix_valid && $stable(luma_addr) && $stable(chroma_addr)
      && $stable(pix_row) && $stable(pix_col) && $stable(pix_quad));

  // R2
  scan_range_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (32'(pix_col) < 32'(COLS)) && (32'(pix_row) < 32'(ROWS)));

  // R3
  luma_map_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> 32'(luma_addr) == 32'(pix_row) * 32'(COLS) + 32'(pix_col));

  // R4
  chroma_map_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> 32'(chroma_addr) == (32'(pix_row) / 32'd2) * 32'(COLS / 2) + 32'(pix_col) / 32'd2);

  // R7
  frame_marks_line_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid && frame_start |-> line_start);

  // R9
  valid_no_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> pix_valid);

endmodule

bind yuv420_scan_addr yuv420_scan_chk #(.COLS(COLS), .ROWS(ROWS)) u_scan_chk (
  .clk         (clk),
  .rst         (rst),
  .pix_ready   (pix_ready),
  .pix_valid   (pix_valid),
  .luma_addr   (luma_addr),
  .chroma_addr (chroma_addr),
  .pix_row     (pix_row),
  .pix_col     (pix_col),
  .pix_quad    (pix_quad),
  .line_start  (line_start),
  .frame_start (frame_start)
);

// File: tb/tb_yuv420_scan_addr.sv
module tb_yuv420_scan_addr;

  localparam int COLS = 10;
  localparam int ROWS = 6;
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);
  localparam int LUMA_W = $clog2(COLS * ROWS);
  localparam int CHROMA_W = $clog2((COLS / 2) * (ROWS / 2));

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                pix_ready = 1'b0;
  logic                pix_valid;
  logic [LUMA_W-1:0]   luma_addr;
  logic [CHROMA_W-1:0] chroma_addr;
  logic [ROW_W-1:0]    pix_row;
  logic [COL_W-1:0]    pix_col;
  logic [1:0]          pix_quad;
  logic                line_start;
  logic                frame_start;

  always #4 clk = ~clk;

  yuv420_scan_addr #(.COLS(COLS), .ROWS(ROWS)) dut (
    .clk (clk), .rst (rst), .pix_ready (pix_ready), .pix_valid (pix_valid),
    .luma_addr (luma_addr), .chroma_addr (chroma_addr), .pix_row (pix_row),
    .pix_col (pix_col), .pix_quad (pix_quad), .line_start (line_start),
    .frame_start (frame_start)
  );

  int checks = 0;
  int errors = 0;

  // Reference model state
  bit e_valid = 0;
  int e_row = 0, e_col = 0, m_row = 0, m_col = 0;
  bit e_wrap = 0, e_first = 0, stalled = 0;
  int p_luma = 0, p_chroma = 0, p_row = 0, p_col = 0, p_quad = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    if (!e_valid) begin
      chk(pix_valid == 1'b0, "R1 valid low in reset", int'(pix_valid), 0);
      return;
    end
    chk(pix_valid == 1'b1, "R9 valid held high", int'(pix_valid), 1);
    chk(int'(pix_row) == e_row, "R2 row", int'(pix_row), e_row);
    chk(int'(pix_col) == e_col, "R2 col", int'(pix_col), e_col);
    chk(int'(luma_addr) == e_row * COLS + e_col, "R3 luma", int'(luma_addr), e_row * COLS + e_col);
    chk(int'(chroma_addr) == (e_row / 2) * (COLS / 2) + e_col / 2, "R4 chroma",
        int'(chroma_addr), (e_row / 2) * (COLS / 2) + e_col / 2);
    chk(int'(pix_quad) == (e_row % 2) * 2 + (e_col % 2), "R5 quad", int'(pix_quad),
        (e_row % 2) * 2 + (e_col % 2));
    chk(line_start == (e_col == 0), "R6 line_start", int'(line_start), int'(e_col == 0));
    chk(frame_start == (e_row == 0 && e_col == 0), "R7 frame_start", int'(frame_start),
        int'(e_row == 0 && e_col == 0));
    if (e_first) begin
      chk(luma_addr == '0 && chroma_addr == '0 && frame_start, "R1 first beat after reset",
          int'(luma_addr), 0);
    end
    if (e_wrap) begin
      chk(luma_addr == '0 && chroma_addr == '0 && pix_row == '0 && pix_col == '0,
          "R10 frame wrap", int'(luma_addr), 0);
    end
    if (stalled) begin
      chk(int'(luma_addr) == p_luma && int'(chroma_addr) == p_chroma && int'(pix_row) == p_row
          && int'(pix_col) == p_col && int'(pix_quad) == p_quad, "R8 held beat stable",
          int'(luma_addr), p_luma);
    end
    p_luma = int'(luma_addr); p_chroma = int'(chroma_addr);
    p_row = int'(pix_row); p_col = int'(pix_col); p_quad = int'(pix_quad);
  endtask

  task automatic model_step();
    stalled = 0; e_wrap = 0; e_first = 0;
    if (rst) begin
      e_valid = 0; m_row = 0; m_col = 0;
    end else if (!e_valid || pix_ready) begin
      e_first = !e_valid;
      e_wrap  = e_valid && e_row == ROWS - 1 && e_col == COLS - 1;
      e_valid = 1; e_row = m_row; e_col = m_col;
      if (m_col == COLS - 1) begin
        m_col = 0;
        m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
      end else begin
        m_col = m_col + 1;
      end
    end else begin
      stalled = 1;
    end
  endtask

  initial begin
    for (int cyc = 0; cyc < 900; cyc++) begin
      @(negedge clk);
      compare();
      rst = (cyc < 3) || (cyc >= 500 && cyc < 503);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (cyc < 200) pix_ready = 1'b1;
      else if (cyc < 500) pix_ready = lfsr[0];
      else if (cyc < 700) pix_ready = (cyc % 3) != 0;
      else pix_ready = 1'b1;
      model_step();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule